// File: doc/BRIEF.md
# Frame Sync Strobe Generator

This block produces a single frame sync line that travels beside a bit-serial data stream whose bits carry no framing of their own. A serializer upstream presents one data bit, with markers for the opening and closing bit of a frame, on each cycle where the bit-clock enable is high. The block returns the data bit on its own output, together with a strobe whose shape follows one of three patterns: one bit wide on the opening bit, one bit wide on the closing bit, or covering every bit of the frame.

The data output can be held back by a programmable number of bit times, from 0 to 15. The strobe is never delayed, so with a non-zero count the strobe leads the matching data by that many bits. The strobe polarity can be inverted. Both outputs are registered and change only at bit-clock enables. Configuration is expected to change only between frames.

Top module: `fss_gen`

## Requirements
- R1: While reset is applied (synchronous, active low), `data_out` is driven to 0, the strobe is cleared, and `fss_out` sits at its inactive level, which is `cfg_invert`.
- R2: Both outputs update only at a clock edge where `bit_en` is high. They hold their values on every other cycle while the configuration is unchanged.
- R3: With `cfg_shape` = 2'b00, the strobe is active for exactly the bit period that follows the edge that captured a bit with `sof` high. It is inactive for all other bits.
- R4: With `cfg_shape` = 2'b01, the strobe is active for exactly the bit period that follows the edge that captured a bit with `eof` high. It is inactive for all other bits.
- R5: With `cfg_shape` = 2'b10, the strobe is active from the bit carrying `sof` through the bit carrying `eof`, both included. A bit with `sof` and `eof` both high makes a one-bit frame.
- R6: With `cfg_shape` = 2'b10, when the bit after an `eof` bit carries `sof`, the strobe stays active with no inactive bit between the two frames.
- R7: After each `bit_en` edge, `data_out` shows the data bit that was captured `cfg_offset` bit enables earlier (0 means the bit just captured; the maximum is 15). The strobe timing does not depend on `cfg_offset`.
- R8: `fss_out` is the active-high strobe XOR `cfg_invert`. With `cfg_invert` = 1, the active level is 0 and the idle level is 1.
- R9: `cfg_shape` = 2'b11 is reserved. In that setting the strobe stays inactive whatever the markers do, while `data_out` keeps working.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Bit-clock enable; one serial bit per high cycle |
| sof | input | 1 | Current bit opens a frame |
| eof | input | 1 | Current bit closes a frame |
| data_in | input | 1 | Serial data bit |
| cfg_shape | input | 2 | Strobe shape: 00 opening bit, 01 closing bit, 10 whole frame, 11 off |
| cfg_offset | input | 4 | Bit times of delay applied to the data output |
| cfg_invert | input | 1 | Invert the strobe polarity |
| data_out | output | 1 | Delayed serial data bit |
| fss_out | output | 1 | Frame sync strobe |

## Verification
The bench goes after one-bit frames in every shape. A design that treats `sof` and `eof` in turn rather than together would either miss that strobe or stretch it into the next bit. Back-to-back whole-frame traffic, with bits on consecutive enables, exposes a tracker that clears on `eof` before it looks at the following `sof`; such a design would show a one-bit gap. Delays of 0, 1, 5 and 15 bits catch an off-by-one tap or a delay applied to the strobe instead of the data. Idle cycles between enables catch any output that moves without a bit clock.

// File: rtl/fss_pkg.sv
// Package: shared type for the frame sync strobe generator.
// Assumes: the shape encoding is fixed by the port contract (00/01/10/11).
package fss_pkg;

    typedef enum logic [1:0] {
        FSS_SHAPE_OPEN  = 2'b00,
        FSS_SHAPE_CLOSE = 2'b01,
        FSS_SHAPE_SPAN  = 2'b10,
        FSS_SHAPE_NONE  = 2'b11
    } fss_shape_e;

endpackage

// File: rtl/fss_delay_line.sv
// Module: fss_delay_line
// Holds back the serial data by a selectable number of bit times.
// Assumes: the tap changes only between frames; stage 0 holds the bit
// captured at the most recent enable, so a tap of 0 adds no extra delay.
module fss_delay_line #(
    parameter int OFF_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             din,
    input  logic [OFF_W-1:0] tap,
    output logic             dout
);
    localparam int DEPTH = 1 << OFF_W;

    logic [DEPTH-1:0] hist;

    // Shift one stage per bit enable; stage 0 receives the incoming bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (bit_en) begin
            hist <= {hist[DEPTH-2:0], din};
        end
    end

    // Select the stage that holds the bit captured tap enables ago.
    always_comb begin
        dout = hist[tap];
    end

endmodule

// File: rtl/fss_frame_track.sv
// Module: fss_frame_track
// Tracks whether the serial stream is inside a frame after the current bit.
// Assumes: markers are valid only on bit_en cycles; a bit with both markers
// is a complete one-bit frame.
module fss_frame_track (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic sof,
    input  logic eof,
    output logic in_frame
);
    // An opening bit enters the frame, a closing bit leaves it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
        end else if (bit_en) begin
            in_frame <= (sof | in_frame) & ~eof;
        end
    end

endmodule

// File: rtl/fss_shaper.sv
// Module: fss_shaper
// Produces the active-high strobe for the bit being captured.
// Assumes: in_frame reflects the bits before the current one; the shape is
// stable for the duration of a frame.
module fss_shaper
    import fss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       sof,
    input  logic       eof,
    input  logic       in_frame,
    input  fss_shape_e shape,
    output logic       strobe
);
    logic strobe_nxt;

    // Choose the strobe level of the current bit from the selected shape.
    always_comb begin
        unique case (shape)
            FSS_SHAPE_OPEN:  strobe_nxt = sof;
            FSS_SHAPE_CLOSE: strobe_nxt = eof;
            FSS_SHAPE_SPAN:  strobe_nxt = sof | in_frame;
            default:         strobe_nxt = 1'b0;
        endcase
    end

    // Register the strobe so it lines up with the registered data bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe <= 1'b0;
        end else if (bit_en) begin
            strobe <= strobe_nxt;
        end
    end

endmodule

// File: rtl/fss_gen.sv
// Module: fss_gen (top)
// Frame sync strobe generator beside a bit-serial data stream. The data is
// delayed by cfg_offset bit times. The strobe is not delayed, so it leads
// the data by that count. Polarity is applied last.
// Assumes: the configuration changes only between frames.
module fss_gen
    import fss_pkg::*;
#(
    parameter int OFF_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             sof,
    input  logic             eof,
    input  logic             data_in,
    input  logic [1:0]       cfg_shape,
    input  logic [OFF_W-1:0] cfg_offset,
    input  logic             cfg_invert,
    output logic             data_out,
    output logic             fss_out
);
    logic       in_frame;
    logic       strobe;
    fss_shape_e shape;

    // Map the raw shape code onto the shared enumeration.
    always_comb begin
        shape = fss_shape_e'(cfg_shape);
    end

    fss_delay_line #(.OFF_W(OFF_W)) u_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .din    (data_in),
        .tap    (cfg_offset),
        .dout   (data_out)
    );

    fss_frame_track u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .sof      (sof),
        .eof      (eof),
        .in_frame (in_frame)
    );

    fss_shaper u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .sof      (sof),
        .eof      (eof),
        .in_frame (in_frame),
        .shape    (shape),
        .strobe   (strobe)
    );

    // Apply the selected polarity to the strobe.
    always_comb begin
        fss_out = strobe ^ cfg_invert;
    end

endmodule

// File: rtl/fss_gen_checker.sv
// Module: fss_gen_checker
// Temporal checks on the ports of fss_gen, attached by bind below.
// Assumes: the configuration is stable between a bit and the bit after it.
module fss_gen_checker #(
    parameter int OFF_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             sof,
    input logic             eof,
    input logic             data_in,
    input logic [1:0]       cfg_shape,
    input logic [OFF_W-1:0] cfg_offset,
    input logic             cfg_invert,
    input logic             data_out,
    input logic             fss_out
);
    // R1: reset drives the idle state
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (data_out == 1'b0 && fss_out == cfg_invert));

    // R2: no movement without a bit enable
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && rst_n) |=> (!rst_n || !$stable(cfg_offset) || !$stable(cfg_invert) ||
                                ($stable(fss_out) && $stable(data_out))));

    // R3: opening-bit shape marks the opening bit
    a_r3_open_active: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && sof && cfg_shape == 2'b00) |=> (fss_out ^ cfg_invert));

    // R3: opening-bit shape stays inactive elsewhere
    a_r3_open_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !sof && cfg_shape == 2'b00) |=> !(fss_out ^ cfg_invert));

    // R4: closing-bit shape marks the closing bit
    a_r4_close_active: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && eof && cfg_shape == 2'b01) |=> (fss_out ^ cfg_invert));

    // R5: whole-frame shape covers both ends
    a_r5_span_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && (sof || eof) && cfg_shape == 2'b10) |=> (fss_out ^ cfg_invert));

    // R7: a zero offset passes the captured bit straight through
    a_r7_zero_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && cfg_offset == '0) |=> (cfg_offset != '0 || data_out == $past(data_in)));

    // R9: reserved shape keeps the strobe inactive
    a_r9_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && cfg_shape == 2'b11) |=> !(fss_out ^ cfg_invert));

endmodule

bind fss_gen fss_gen_checker #(.OFF_W(OFF_W)) u_fss_gen_checker (.*);

// File: tb/test_fss_gen.sv
// Scoreboard bench for fss_gen: the driver models each bit and queues the
// expected outputs, and the monitor compares them after every bit enable.
module test_fss_gen;
    localparam int CLK_PERIOD = 10;
    localparam int OFF_W      = 4;
    localparam int DEPTH      = 1 << OFF_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bit_en = 1'b0;
    logic             sof = 1'b0;
    logic             eof = 1'b0;
    logic             data_in = 1'b0;
    logic [1:0]       cfg_shape = 2'b00;
    logic [OFF_W-1:0] cfg_offset = '0;
    logic             cfg_invert = 1'b0;
    logic             data_out;
    logic             fss_out;

    typedef struct {
        logic  fss;
        logic  dat;
        string tag;
    } exp_t;

    exp_t        q[$];
    int          checks = 0;
    int          fails = 0;
    bit          m_in = 1'b0;
    bit          m_hist[DEPTH];
    string       cur_tag = "R1";
    logic        last_fss = 1'b0;
    logic        last_dat = 1'b0;
    bit          have_last = 1'b0;
    bit          done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    fss_gen #(.OFF_W(OFF_W)) i_fss_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .sof        (sof),
        .eof        (eof),
        .data_in    (data_in),
        .cfg_shape  (cfg_shape),
        .cfg_offset (cfg_offset),
        .cfg_invert (cfg_invert),
        .data_out   (data_out),
        .fss_out    (fss_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // Apply reset starting from a negedge; the outputs are checked at the idle level.
    task automatic do_reset(string tag);
        rst_n  = 1'b0;
        bit_en = 1'b0;
        sof    = 1'b0;
        eof    = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_in  = 1'b0;
        foreach (m_hist[i]) m_hist[i] = 1'b0;
        have_last = 1'b0;
        check(tag, "fss_out after reset", fss_out, cfg_invert);
        check(tag, "data_out after reset", data_out, 1'b0);
    endtask

    // Change the configuration at a negedge while no bit is being sent.
    task automatic set_cfg(logic [1:0] shp, logic [OFF_W-1:0] off, logic inv);
        cfg_shape  = shp;
        cfg_offset = off;
        cfg_invert = inv;
        have_last  = 1'b0;
        @(negedge clk);
    endtask

    // Driver: present one bit for one cycle, queue its expected outputs, then idle for gap cycles.
    task automatic send_bit(logic d, logic s, logic e, int gap);
        exp_t it;
        logic raw;
        data_in = d;
        sof     = s;
        eof     = e;
        bit_en  = 1'b1;
        case (cfg_shape)
            2'b00:   raw = s;
            2'b01:   raw = e;
            2'b10:   raw = s | m_in;
            default: raw = 1'b0;
        endcase
        m_in = (s | m_in) & ~e;
        for (int i = DEPTH - 1; i > 0; i--) m_hist[i] = m_hist[i-1];
        m_hist[0] = d;
        it.dat = m_hist[cfg_offset];
        it.fss = raw ^ cfg_invert;
        it.tag = cur_tag;
        q.push_back(it);
        @(negedge clk);
        bit_en = 1'b0;
        sof    = 1'b0;
        eof    = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic next_data(output logic d);
        d    = lfsr[0];
        lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    endtask

    task automatic send_frame(int len, int gap);
        logic d;
        for (int i = 0; i < len; i++) begin
            next_data(d);
            send_bit(d, i == 0, i == len - 1, gap);
        end
    endtask

    task automatic send_idle_bits(int n, int gap);
        logic d;
        for (int i = 0; i < n; i++) begin
            next_data(d);
            send_bit(d, 1'b0, 1'b0, gap);
        end
    endtask

    // Monitor: pop and compare after each enabled edge; check holding on idle cycles (R2).
    initial begin
        forever begin
            bit   fired;
            exp_t it;
            @(posedge clk);
            fired = bit_en && rst_n;
            #(CLK_PERIOD/4);
            if (!rst_n) begin
                have_last = 1'b0;
            end else if (fired) begin
                if (q.size() == 0) begin
                    checks++;
                    fails++;
                    $display("FAIL R2 unexpected bit: actual output update expected none");
                end else begin
                    it = q.pop_front();
                    check(it.tag, "fss_out", fss_out, it.fss);
                    check(it.tag, "data_out", data_out, it.dat);
                    last_fss  = it.fss;
                    last_dat  = it.dat;
                    have_last = 1'b1;
                end
            end else if (have_last) begin
                check("R2", "fss_out hold", fss_out, last_fss);
                check("R2", "data_out hold", data_out, last_dat);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state, normal polarity
        do_reset("R1");

        // R3: opening-bit strobe, including a one-bit frame
        cur_tag = "R3";
        set_cfg(2'b00, 4'd0, 1'b0);
        send_frame(6, 2);
        send_frame(1, 1);
        send_idle_bits(4, 1);
        send_frame(3, 0);

        // R4: closing-bit strobe
        cur_tag = "R4";
        set_cfg(2'b01, 4'd0, 1'b0);
        send_frame(5, 1);
        send_frame(1, 2);
        send_frame(8, 0);
        send_idle_bits(2, 1);

        // R5: whole-frame strobe with idle bits around frames and a one-bit frame
        cur_tag = "R5";
        set_cfg(2'b10, 4'd0, 1'b0);
        send_frame(7, 1);
        send_idle_bits(3, 1);
        send_frame(1, 1);
        send_idle_bits(2, 2);

        // R6: back-to-back whole frames on consecutive enables
        cur_tag = "R6";
        send_frame(4, 0);
        send_frame(3, 0);
        send_frame(1, 0);
        send_frame(5, 1);
        send_idle_bits(2, 1);

        // R7: data delay of 5, 15 and 1 bit times with the strobe not delayed
        cur_tag = "R7";
        set_cfg(2'b00, 4'd5, 1'b0);
        send_frame(20, 0);
        set_cfg(2'b10, 4'd15, 1'b0);
        send_frame(40, 1);
        send_idle_bits(4, 0);
        set_cfg(2'b01, 4'd1, 1'b0);
        send_frame(9, 2);

        // R8: inverted polarity in two shapes, then reset with inversion
        cur_tag = "R8";
        set_cfg(2'b00, 4'd3, 1'b1);
        send_frame(6, 1);
        set_cfg(2'b10, 4'd0, 1'b1);
        send_frame(5, 0);
        send_idle_bits(3, 1);
        do_reset("R8");

        // R9: reserved shape keeps the strobe quiet while data still flows
        cur_tag = "R9";
        set_cfg(2'b11, 4'd2, 1'b0);
        send_frame(6, 1);
        send_frame(1, 0);
        send_idle_bits(3, 1);

        repeat (4) @(negedge clk);
        check("R2", "scoreboard drained", q.size() == 0, 1'b1);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule